// File: doc/BRIEF.md
# Effective Address Generator for 64-bit Memory Operands

This block turns the addressing fields of an instruction into a memory effective address. The decoder supplies the addressing-form byte, the scale/index/base byte, the two register-extension bits, the raw 32-bit displacement field and the address of the next instruction. The block works out which registers take part and how far the displacement reaches, then forms base + scaled index + displacement (+ next-instruction address), all modulo 2^64. It also supports a narrow 32-bit address mode.

Every combination of inputs gives exactly one registered result, and a valid/ready pair on each side carries it. A request accepted on one clock edge is presented on the outputs from that edge on and stays there until it is consumed. Beside the address, the block reports whether the form was relative to the next instruction, whether a base register took part, whether an index register took part, and whether the form names a register rather than memory.

Top module: `agu64_ea`

## Requirements
- R1: With `mode64`=1, mod=00 and r/m=101 (`modrm[7:6]`=00, `modrm[2:0]`=101), `ea` = `rip` + sign-extended `disp[31:0]`, with `rip_rel`=1, `no_base`=1 and `no_index`=1.
- R2: The relative-to-next-instruction form in R1 is detected on the 3-bit r/m field alone, so `rex_b`=1 still gives R1's result and not register 13.
- R3: With `mode64`=0, both `rex_b` and `rex_x` are ignored and every address is truncated to 32 bits and zero-extended. For mod=00, r/m=101 the result is the zero-extended `disp[31:0]` and `rip_rel`=0.
- R4: The scale/index/base byte is used when mod≠11 and r/m=100. Base field `sib[2:0]`=101 with mod=00 means there is no base register and the sign-extended `disp[31:0]` is added (`no_base`=1). With mod=01 or 10, that same base field selects a register (rBP or R13).
- R5: Index field `sib[5:3]`=100 with the effective index-extension bit at 0 means there is no index (`no_index`=1). With `mode64`=1 and `rex_x`=1 the same field selects register 12.
- R6: The index value is shifted left by `sib[7:6]`, which gives a factor of 1, 2, 4 or 8.
- R7: mod=01 adds the sign-extended `disp[7:0]` and ignores `disp[31:8]`. mod=10 adds the sign-extended `disp[31:0]`. mod=00 adds nothing except in the no-base forms of R1, R3 and R4.
- R8: In 64-bit mode the register number is {`rex_b`, r/m} or {`rex_b`, `sib[2:0]`} for the base and {`rex_x`, `sib[5:3]`} for the index. Register n is read from `gpr_file[64n+63:64n]`.
- R9: All sums wrap modulo 2^64. With `addr32`=1 in 64-bit mode the wrapped sum is then truncated to 32 bits and zero-extended, and the relative form stays active (`rip_rel`=1).
- R10: mod=11 gives `reg_operand`=1, `ea`=0, `rip_rel`=0, `no_base`=1 and `no_index`=1.
- R11: `in_ready` is 1 whenever the output register is empty or `out_ready` is 1. A request accepted at a clock edge appears with `out_valid`=1 after that edge. While `out_valid`=1 and `out_ready`=0 the outputs hold. Results leave in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| modrm | input | 8 | Addressing-form byte |
| sib | input | 8 | Scale/index/base byte |
| rex_b | input | 1 | Base / r/m register extension bit |
| rex_x | input | 1 | Index register extension bit |
| disp | input | 32 | Raw displacement field |
| gpr_file | input | 1024 | 16 registers of 64 bits, register n at bits 64n+63:64n |
| rip | input | 64 | Address of the following instruction |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit compatibility mode |
| addr32 | input | 1 | Address-size override (32-bit addresses in 64-bit mode) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result consumed |
| ea | output | 64 | Effective address |
| rip_rel | output | 1 | Address was formed relative to the next instruction |
| no_base | output | 1 | No base register took part |
| no_index | output | 1 | No index register took part |
| reg_operand | output | 1 | Form names a register, no address |

## Verification
The bench targets the encodings that look like registers but are not. The relative form with `rex_b` set is checked because a full 4-bit decode would read R13 instead. The base-101 field is checked under mod=00 and under mod=01, because mixing the two either loses the displacement or drops the base. Index 100 is checked with and without the index-extension bit, because a 3-bit-only decode would silently drop R12. The bench also checks ignored upper displacement bytes under mod=01, REX bits in compatibility mode, 64-bit wraparound ahead of 32-bit truncation, and results under back-pressure, where a bad hold or ready path shows up as lost, duplicated or reordered items in the scoreboard.

// File: rtl/agu64_ea.sv
`timescale 1ns/1ps
module agu64_ea #(
  parameter int XLEN = 64,
  parameter int DW   = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [7:0]           modrm,
  input  logic [7:0]           sib,
  input  logic                 rex_b,
  input  logic                 rex_x,
  input  logic [DW-1:0]        disp,
  input  logic [16*XLEN-1:0]   gpr_file,
  input  logic [XLEN-1:0]      rip,
  input  logic                 mode64,
  input  logic                 addr32,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [XLEN-1:0]      ea,
  output logic                 rip_rel,
  output logic                 no_base,
  output logic                 no_index,
  output logic                 reg_operand
);
  localparam int NW = 32;

  logic [1:0] mod_f;
  logic [2:0] rm_f, sbase, sidx;
  logic       ext_b, ext_x, is_reg, use_sib, rip_form, sib_nobase;
  logic       nb_c, ni_c, narrow;
  logic [3:0] base_num, idx_num;
  logic [XLEN-1:0] base_val, idx_val, base_term, idx_term, disp_ext, rip_term, sum, ea_c;

  assign mod_f  = modrm[7:6];
  assign rm_f   = modrm[2:0];
  assign sbase  = sib[2:0];
  assign sidx   = sib[5:3];
  assign ext_b  = mode64 & rex_b;
  assign ext_x  = mode64 & rex_x;

  assign is_reg     = (mod_f == 2'b11);
  assign use_sib    = !is_reg && (rm_f == 3'b100);
  assign rip_form   = (mod_f == 2'b00) && (rm_f == 3'b101);
  assign sib_nobase = use_sib && (mod_f == 2'b00) && (sbase == 3'b101);

  assign nb_c = is_reg || rip_form || sib_nobase;
  assign ni_c = is_reg || !use_sib || ((sidx == 3'b100) && !ext_x);

  assign base_num = {ext_b, use_sib ? sbase : rm_f};
  assign idx_num  = {ext_x, sidx};
  assign base_val = gpr_file[base_num*XLEN +: XLEN];
  assign idx_val  = gpr_file[idx_num*XLEN +: XLEN];

  assign base_term = nb_c ? '0 : base_val;
  assign idx_term  = ni_c ? '0 : (idx_val << sib[7:6]);
  assign rip_term  = (rip_form && mode64) ? rip : '0;

  always_comb begin
    case (mod_f)
      2'b01:   disp_ext = {{(XLEN-8){disp[7]}}, disp[7:0]};
      2'b10:   disp_ext = {{(XLEN-DW){disp[DW-1]}}, disp};
      2'b00:   disp_ext = (rip_form || sib_nobase) ? {{(XLEN-DW){disp[DW-1]}}, disp} : '0;
      default: disp_ext = '0;
    endcase
  end

  assign sum    = base_term + idx_term + disp_ext + rip_term;
  assign narrow = addr32 || !mode64;
  assign ea_c   = is_reg ? '0 : narrow ? {{(XLEN-NW){1'b0}}, sum[NW-1:0]} : sum;

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      ea          <= '0;
      rip_rel     <= 1'b0;
      no_base     <= 1'b0;
      no_index    <= 1'b0;
      reg_operand <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        ea          <= ea_c;
        rip_rel     <= rip_form && mode64;
        no_base     <= nb_c;
        no_index    <= ni_c;
        reg_operand <= is_reg;
      end
    end
  end
endmodule

module agu64_ea_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic        mode64,
  input logic        addr32,
  input logic [63:0] ea,
  input logic        rip_rel,
  input logic        no_base,
  input logic        no_index,
  input logic        reg_operand
);
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(ea) && $stable(rip_rel) && $stable(no_base)); // R11
  AST_ACCEPT_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R11
  AST_READY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R11
  AST_RIP_NO_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && rip_rel |-> no_base && no_index && !reg_operand); // R1
  AST_REGOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && reg_operand |-> ea == 64'd0 && !rip_rel); // R10
  AST_NARROW_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (addr32 || !mode64) |=> ea[63:32] == 32'd0); // R9
  AST_COMPAT_NO_RIP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !mode64 |=> !rip_rel); // R3
endmodule

bind agu64_ea agu64_ea_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .mode64(mode64), .addr32(addr32),
  .ea(ea), .rip_rel(rip_rel), .no_base(no_base), .no_index(no_index),
  .reg_operand(reg_operand)
);

// File: tb/agu64_ea_test.sv
`timescale 1ns/1ps
module agu64_ea_test;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 1;
  logic [7:0] modrm = 0, sib = 0;
  logic rex_b = 0, rex_x = 0, mode64 = 1, addr32 = 0;
  logic [31:0] disp = 0;
  logic [1023:0] gpr_file;
  logic [63:0] rip = 0, ea;
  logic rip_rel, no_base, no_index, reg_operand;
  logic stall_en = 0;
  int cyc = 0, n_chk = 0, n_bad = 0;

  typedef struct {
    string       tag;
    logic [63:0] ea;
    logic        rr, nb, ni, ro;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  agu64_ea uut (.*);

  function automatic logic [63:0] rv(int i);
    return 64'h0101_0101_0101_0101 * 64'(i + 1);
  endfunction

  initial for (int i = 0; i < 16; i++) gpr_file[i*64 +: 64] = rv(i);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    if (stall_en) out_ready = (cyc % 3 == 0);
  end

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      n_chk++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL R11: unexpected result ea=%h, expected none", ea);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (ea !== e.ea || rip_rel !== e.rr || no_base !== e.nb || no_index !== e.ni || reg_operand !== e.ro) begin
          n_bad++;
          $display("FAIL %s: ea=%h rr=%b nb=%b ni=%b ro=%b expected ea=%h rr=%b nb=%b ni=%b ro=%b",
                   e.tag, ea, rip_rel, no_base, no_index, reg_operand, e.ea, e.rr, e.nb, e.ni, e.ro);
        end
      end
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(string tag, logic m64, logic a32, logic rb, logic rx,
                      logic [7:0] mr, logic [7:0] sb_b, logic [31:0] d, logic [63:0] r,
                      logic [63:0] e_ea, logic e_rr, logic e_nb, logic e_ni, logic e_ro);
    exp_t e;
    @(negedge clk);
    mode64 = m64; addr32 = a32; rex_b = rb; rex_x = rx;
    modrm = mr; sib = sb_b; disp = d; rip = r; in_valid = 1;
    e.tag = tag; e.ea = e_ea; e.rr = e_rr; e.nb = e_nb; e.ni = e_ni; e.ro = e_ro;
    sb.push_back(e);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  task automatic run_set();
    logic [63:0] r0 = 64'h0000_7fff_0000_1000;
    send("R1", 1,0,0,0, 8'b00_000_101, 8'h00, 32'h0000_0100, r0, r0 + 64'h100, 1,1,1,0);
    send("R1", 1,0,0,0, 8'b00_111_101, 8'h00, 32'hFFFF_FFF0, r0, r0 - 64'd16, 1,1,1,0);
    send("R2", 1,0,1,1, 8'b00_000_101, 8'h00, 32'h0000_0100, r0, r0 + 64'h100, 1,1,1,0);
    send("R3", 0,0,1,0, 8'b00_000_101, 8'h00, 32'h8000_0000, r0, 64'h8000_0000, 0,1,1,0);
    send("R3", 0,0,0,1, 8'b00_000_100, 8'b00_100_000, 32'h0, r0, {32'h0, rv(0)[31:0]}, 0,0,1,0);
    send("R4", 1,0,0,0, 8'b00_000_100, 8'b00_100_101, 32'h1234_5678, r0, 64'h1234_5678, 0,1,1,0);
    send("R4", 1,0,1,0, 8'b01_000_100, 8'b00_100_101, 32'h0000_0080, r0, rv(13) - 64'd128, 0,0,1,0);
    send("R5", 1,0,0,1, 8'b00_000_100, 8'b00_100_000, 32'h0, r0, rv(0) + rv(12), 0,0,0,0);
    send("R6", 1,0,0,0, 8'b10_000_100, 8'b11_001_010, 32'h7FFF_FFFF, r0,
         rv(2) + (rv(1) << 3) + 64'h7FFF_FFFF, 0,0,0,0);
    send("R6", 1,0,0,0, 8'b00_000_100, 8'b01_011_101, 32'hFFFF_FF00, r0,
         (rv(3) << 1) - 64'd256, 0,1,0,0);
    send("R7", 1,0,0,0, 8'b01_000_000, 8'h00, 32'hABCD_EF7F, r0, rv(0) + 64'h7F, 0,0,1,0);
    send("R7", 1,0,0,0, 8'b00_000_001, 8'h00, 32'hABCD_EF7F, r0, rv(1), 0,0,1,0);
    send("R8", 1,0,1,0, 8'b00_000_011, 8'h00, 32'h0, r0, rv(11), 0,0,1,0);
    send("R8", 0,0,1,0, 8'b10_000_011, 8'h00, 32'h0000_0010, r0,
         {32'h0, rv(3)[31:0] + 32'h10}, 0,0,1,0);
    send("R9", 1,1,0,0, 8'b00_000_101, 8'h00, 32'h0000_0020, 64'h1_FFFF_FFF0, 64'h10, 1,1,1,0);
    send("R9", 1,0,0,0, 8'b00_000_101, 8'h00, 32'h0000_0020, 64'hFFFF_FFFF_FFFF_FFF0, 64'h10, 1,1,1,0);
    send("R10", 1,0,1,1, 8'b11_000_001, 8'h00, 32'h1234_5678, r0, 64'h0, 0,1,1,1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset out_valid", 64'(out_valid), 64'd0);
    check("R11 reset in_ready", 64'(in_ready), 64'd1);
    rst_n = 1;
    send("R1", 1,0,0,0, 8'b00_000_101, 8'h00, 32'h4, 64'h100, 64'h104, 1,1,1,0);
    @(negedge clk);
    check("R11 latency", 64'(out_valid), 64'd1);
    run_set();
    stall_en = 1;
    run_set();
    for (int k = 0; k < 200 && sb.size() != 0; k++) @(negedge clk);
    stall_en = 0;
    check("R11 all results drained", 64'(sb.size()), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL R11: watchdog expired, actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule